// File: doc/BRIEF.md
# Fractional PLL Frequency Calculator

This block works out, in hardware, the clock frequencies that a clock-control unit would produce for a given set of settings. It takes the fields of a fractional-N PLL setting, a reference-source choice, two core-source flags and two post-divider fields. From these it computes three 32-bit frequency values in hertz: the core clock, the high-speed clock derived from it, and the peripheral bus clock derived from that.

The PLL output is `(2 * (ref >> 10) * (mi * md + mn)) / (md * pd)`, and the quotient is then shifted left by 10. All three divisions share one restoring divider that produces one quotient bit per cycle. A pulse on `start` launches a computation, and `done` pulses once all three results are published together. A strobe that arrives while a computation is running is remembered and served as soon as the current one ends.

Top module: `pllFreqCalc`

## Requirements
- R1: The PLL fields are used as follows. The effective pre-divider `pd` is `preDiv + 1` and the effective denominator `md` is `mulDenom + 1`. The effective integer part `mi` is `mulInt`, but any value below 5 is replaced by 5.
- R2: `mulNumer` is a signed 10-bit two's-complement value `mn`. The PLL output is `((2 * (ref >> 10) * (mi * md + mn)) / (md * pd)) << 10`. Every sum and product wraps as an unsigned 32-bit value, and the division truncates.
- R3: The reference `ref` is 33554432 Hz (32768 * 1024) when `refSel` equals 2'b10. For any other `refSel` value it is 26000000 Hz.
- R4: `coreFreq` equals `ref` when `forceRef` is 1 or `pllEnable` is 0. Otherwise it equals the PLL output.
- R5: `hsFreq` is `coreFreq / (hsDiv + 1)` and `perFreq` is `hsFreq / (perDiv + 1)`, both truncating.
- R6: `done` is high for exactly one cycle per computation. The three frequency outputs change only in the cycle `done` rises, all together, and hold their values at every other time.
- R7: After reset the three frequency outputs are 0 and `done` is low.
- R8: All setting inputs are sampled on the clock edge that launches a computation. Changes to them afterwards do not affect that computation's results.
- R9: A `start` seen while a computation is running is held and launches a new computation, using the inputs present at that point, on the edge after `done` rises. Several such strobes during one computation collapse into a single extra computation.
- R10: A `start` on the same edge that publishes a result is not lost. It launches a computation on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe |
| refSel | input | 2 | Reference source choice; 2'b10 selects the scaled 32 kHz source |
| pllEnable | input | 1 | 1 lets the core clock come from the PLL |
| forceRef | input | 1 | 1 forces the core clock to the reference |
| preDiv | input | 4 | PLL pre-divider field |
| mulDenom | input | 10 | PLL fraction denominator field |
| mulInt | input | 4 | PLL integer multiplier field |
| mulNumer | input | 10 | PLL signed fraction numerator |
| hsDiv | input | 3 | High-speed clock divider field |
| perDiv | input | 2 | Peripheral clock divider field |
| coreFreq | output | 32 | Core clock frequency in Hz |
| hsFreq | output | 32 | High-speed clock frequency in Hz |
| perFreq | output | 32 | Peripheral clock frequency in Hz |
| done | output | 1 | One-cycle pulse when the three results are published |

## Verification
Two events can meet on one clock edge: the publication of a result and a fresh `start` strobe. The bench first measures how long a PLL computation takes. On the next run it raises `start` so that it is sampled on exactly the edge that publishes that run's result, with new settings already on the inputs. The scoreboard then expects two results in order, the second computed from the new settings, and flags any missing or surplus `done`.

// File: rtl/pllCalcPkg.sv
package pllCalcPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_WPLL, ST_SHS, ST_WHS, ST_SPER, ST_WPER
  } calcState_t;

  typedef struct packed {
    logic capture;   // latch the settings
    logic bypass;    // core = reference
    logic loadPll;   // start PLL division
    logic takeCore;  // core = quotient << shift
    logic loadHs;    // start high-speed division
    logic takeHs;    // hs = quotient
    logic loadPer;   // start peripheral division
    logic takePer;   // publish all results
  } calcStb_t;
endpackage

// File: rtl/pllCalcDivider.sv
module pllCalcDivider #(
  parameter int N  = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [N-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic [N-1:0]  quotient,
  output logic          divDone
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cntQ;
  logic          busyQ, doneQ;
  logic [DW-1:0] remQ, divQ, nextRem;
  logic [N-1:0]  quoQ;
  logic [DW:0]   trial, diff;
  logic          ge;

  always_comb begin
    trial   = {remQ, quoQ[N-1]};
    ge      = trial >= {1'b0, divQ};
    diff    = trial - {1'b0, divQ};
    nextRem = ge ? diff[DW-1:0] : trial[DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0; busyQ <= 1'b0; doneQ <= 1'b0;
      remQ <= '0; divQ <= '0; quoQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (load) begin
        remQ  <= '0;
        quoQ  <= dividend;
        divQ  <= divisor;
        cntQ  <= CW'(N);
        busyQ <= 1'b1;
      end else if (busyQ) begin
        remQ <= nextRem;
        quoQ <= {quoQ[N-2:0], ge};
        cntQ <= cntQ - CW'(1);
        if (cntQ == CW'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign quotient = quoQ;
  assign divDone  = doneQ;

  // R5: control never reloads the shared divider mid-run
  p_load_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    load |-> !busyQ);
  // R5: a finished restoring division leaves a remainder below the divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (remQ < divQ));
endmodule

// File: rtl/pllCalcDatapath.sv
module pllCalcDatapath
  import pllCalcPkg::*;
#(
  parameter int          FW       = 32,
  parameter int          DW       = 16,
  parameter int          SHIFT    = 10,
  parameter logic [31:0] REF_FAST = 32'd26000000,
  parameter logic [31:0] REF_SLOW = 32'd32768
) (
  input  logic          clk,
  input  logic          rstN,
  input  calcStb_t      stb,
  input  logic [1:0]    refSel,
  input  logic          pllEnable,
  input  logic          forceRef,
  input  logic [3:0]    preDiv,
  input  logic [9:0]    mulDenom,
  input  logic [3:0]    mulInt,
  input  logic [9:0]    mulNumer,
  input  logic [2:0]    hsDiv,
  input  logic [1:0]    perDiv,
  output logic          usePll,
  output logic          divDone,
  output logic [FW-1:0] coreOut,
  output logic [FW-1:0] hsOut,
  output logic [FW-1:0] perOut
);
  localparam logic [FW-1:0] REF_SCALED = FW'(REF_SLOW) << SHIFT;
  localparam logic [3:0]    MI_MIN     = 4'd5;

  logic [1:0]    refSelQ, perQ;
  logic          pllEnQ, forceQ;
  logic [3:0]    pdQ, miQ;
  logic [9:0]    mdQ, mnQ;
  logic [2:0]    hsQ;
  logic [FW-1:0] coreW, hsW;

  logic [FW-1:0] refF, mnExt, term, num, divA, quot;
  logic [3:0]    miEff;
  logic [10:0]   mdEff;
  logic [4:0]    pdEff;
  logic [DW-1:0] den, divB;
  logic          divLoad;

  always_comb begin
    refF  = (refSelQ == 2'b10) ? REF_SCALED : FW'(REF_FAST);
    miEff = (miQ < MI_MIN) ? MI_MIN : miQ;
    mdEff = {1'b0, mdQ} + 11'd1;
    pdEff = {1'b0, pdQ} + 5'd1;
    mnExt = {{(FW-10){mnQ[9]}}, mnQ};
    term  = FW'(miEff) * FW'(mdEff) + mnExt;
    num   = FW'(2) * (refF >> SHIFT) * term;
    den   = DW'(mdEff) * DW'(pdEff);
  end

  assign usePll  = pllEnQ & ~forceQ;
  assign divLoad = stb.loadPll | stb.loadHs | stb.loadPer;

  always_comb begin
    if (stb.loadPll) begin
      divA = num;   divB = den;
    end else if (stb.loadHs) begin
      divA = coreW; divB = DW'(hsQ) + DW'(1);
    end else begin
      divA = hsW;   divB = DW'(perQ) + DW'(1);
    end
  end

  pllCalcDivider #(.N(FW), .DW(DW)) uDiv (
    .clk(clk), .rstN(rstN), .load(divLoad), .dividend(divA),
    .divisor(divB), .quotient(quot), .divDone(divDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSelQ <= '0; pllEnQ <= 1'b0; forceQ <= 1'b0;
      pdQ <= '0; miQ <= '0; mdQ <= '0; mnQ <= '0; hsQ <= '0; perQ <= '0;
      coreW <= '0; hsW <= '0; coreOut <= '0; hsOut <= '0; perOut <= '0;
    end else begin
      if (stb.capture) begin
        refSelQ <= refSel; pllEnQ <= pllEnable; forceQ <= forceRef;
        pdQ <= preDiv; miQ <= mulInt; mdQ <= mulDenom; mnQ <= mulNumer;
        hsQ <= hsDiv; perQ <= perDiv;
      end
      if (stb.bypass)   coreW <= refF;
      if (stb.takeCore) coreW <= quot << SHIFT;
      if (stb.takeHs)   hsW   <= quot;
      if (stb.takePer) begin
        coreOut <= coreW;
        hsOut   <= hsW;
        perOut  <= quot;
      end
    end
  end

  // R1: the captured integer field never reaches the formula below the floor
  p_mi_floor_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadPll |-> (miEff >= MI_MIN && den != '0));
endmodule

// File: rtl/pllCalcCtrl.sv
module pllCalcCtrl
  import pllCalcPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     usePll,
  input  logic     divDone,
  output calcStb_t stb,
  output logic     done
);
  calcState_t stateQ, stateD;
  logic       pendQ, doneQ;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start || pendQ) begin stb.capture = 1'b1; stateD = ST_ARM; end
      ST_ARM: begin
        if (usePll) begin stb.loadPll = 1'b1; stateD = ST_WPLL; end
        else        begin stb.bypass  = 1'b1; stateD = ST_SHS;  end
      end
      ST_WPLL: if (divDone) begin stb.takeCore = 1'b1; stateD = ST_SHS; end
      ST_SHS:  begin stb.loadHs = 1'b1; stateD = ST_WHS; end
      ST_WHS:  if (divDone) begin stb.takeHs = 1'b1; stateD = ST_SPER; end
      ST_SPER: begin stb.loadPer = 1'b1; stateD = ST_WPER; end
      ST_WPER: if (divDone) begin stb.takePer = 1'b1; stateD = ST_IDLE; end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE; pendQ <= 1'b0; doneQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= stb.takePer;
      if (stateQ == ST_IDLE) pendQ <= 1'b0;
      else if (start)        pendQ <= 1'b1;
    end
  end

  assign done = doneQ;

  // R9: a strobe during a run is remembered
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && stateQ != ST_IDLE) |=> pendQ);
  // R9: a remembered strobe launches from idle at once
  p_pend_launch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && pendQ) |=> (stateQ == ST_ARM));
  // R10: a strobe on the publishing edge leaves a pending launch behind
  p_edge_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takePer && start) |=> (pendQ && stateQ == ST_IDLE));
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
endmodule

// File: rtl/pllFreqCalc.sv
module pllFreqCalc
  import pllCalcPkg::*;
#(
  parameter int FW    = 32,
  parameter int DW    = 16,
  parameter int SHIFT = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    refSel,
  input  logic          pllEnable,
  input  logic          forceRef,
  input  logic [3:0]    preDiv,
  input  logic [9:0]    mulDenom,
  input  logic [3:0]    mulInt,
  input  logic [9:0]    mulNumer,
  input  logic [2:0]    hsDiv,
  input  logic [1:0]    perDiv,
  output logic [FW-1:0] coreFreq,
  output logic [FW-1:0] hsFreq,
  output logic [FW-1:0] perFreq,
  output logic          done
);
  calcStb_t stb;
  logic     usePll, divDone;

  pllCalcCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .usePll(usePll),
    .divDone(divDone), .stb(stb), .done(done)
  );

  pllCalcDatapath #(.FW(FW), .DW(DW), .SHIFT(SHIFT)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .refSel(refSel),
    .pllEnable(pllEnable), .forceRef(forceRef), .preDiv(preDiv),
    .mulDenom(mulDenom), .mulInt(mulInt), .mulNumer(mulNumer),
    .hsDiv(hsDiv), .perDiv(perDiv), .usePll(usePll), .divDone(divDone),
    .coreOut(coreFreq), .hsOut(hsFreq), .perOut(perFreq)
  );

  // R6: results move only together with the done pulse
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({coreFreq, hsFreq, perFreq}));
endmodule

// File: tb/sim_pllFreqCalc.sv
module sim_pllFreqCalc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0]  refSel = '0, perDiv = '0;
  logic        pllEnable = 1'b0, forceRef = 1'b0;
  logic [3:0]  preDiv = '0, mulInt = '0;
  logic [9:0]  mulDenom = '0, mulNumer = '0;
  logic [2:0]  hsDiv = '0;
  logic [31:0] coreFreq, hsFreq, perFreq;
  logic        done;

  int checks = 0, failures = 0;
  int cyc = 0, startCyc = 0, lastDoneCyc = 0;
  logic [31:0] expCore[$], expHs[$], expPer[$];
  string       expTag[$];
  logic [31:0] lastC = '0, lastH = '0, lastP = '0, prevC = '0, prevH = '0, prevP = '0;
  logic        prevDone = 1'b0;

  pllFreqCalc u0 (
    .clk(clk), .rstN(rstN), .start(start), .refSel(refSel),
    .pllEnable(pllEnable), .forceRef(forceRef), .preDiv(preDiv),
    .mulDenom(mulDenom), .mulInt(mulInt), .mulNumer(mulNumer),
    .hsDiv(hsDiv), .perDiv(perDiv), .coreFreq(coreFreq),
    .hsFreq(hsFreq), .perFreq(perFreq), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(output logic [31:0] c, output logic [31:0] h,
                                output logic [31:0] p);
    logic [31:0] r, mi, md, pd, mn, term, num;
    r = (refSel == 2'b10) ? 32'd33554432 : 32'd26000000;
    if (forceRef || !pllEnable) c = r;
    else begin
      mi = {28'b0, mulInt};
      if (mi < 32'd5) mi = 32'd5;
      md = {22'b0, mulDenom} + 32'd1;
      pd = {28'b0, preDiv} + 32'd1;
      mn = {{22{mulNumer[9]}}, mulNumer};
      term = mi * md + mn;
      num = 32'd2 * (r >> 10) * term;
      c = (num / (md * pd)) << 10;
    end
    h = c / ({29'b0, hsDiv} + 32'd1);
    p = h / ({30'b0, perDiv} + 32'd1);
  endfunction

  task automatic setIn(input logic [1:0] rs, input logic pe, input logic fr,
                       input logic [3:0] pdv, input logic [9:0] md,
                       input logic [3:0] mi, input logic [9:0] mn,
                       input logic [2:0] hd, input logic [1:0] prd);
    refSel = rs; pllEnable = pe; forceRef = fr; preDiv = pdv;
    mulDenom = md; mulInt = mi; mulNumer = mn; hsDiv = hd; perDiv = prd;
  endtask

  // driver: push the expectation from the present inputs, then strobe
  task automatic pushExp(input string tag);
    logic [31:0] c, h, p;
    model(c, h, p);
    expCore.push_back(c); expHs.push_back(h); expPer.push_back(p);
    expTag.push_back(tag);
  endtask

  task automatic pulseStart(input string tag);
    @(negedge clk);
    pushExp(tag);
    start = 1'b1; startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expCore.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop and compare on every done
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) check("R6", "done width", {31'b0, done}, 32'd0);
      if (done) begin
        check("R6", "core held before done", prevC, lastC);
        check("R6", "hs held before done", prevH, lastH);
        check("R6", "per held before done", prevP, lastP);
        if (expCore.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 surplus done actual=1 expected=0");
        end else begin
          string t;
          t = expTag.pop_front();
          check(t, "coreFreq", coreFreq, expCore.pop_front());
          check(t, "hsFreq", hsFreq, expHs.pop_front());
          check(t, "perFreq", perFreq, expPer.pop_front());
        end
        lastC = coreFreq; lastH = hsFreq; lastP = perFreq;
        lastDoneCyc = cyc;
      end
      prevDone = done;
      prevC = coreFreq; prevH = hsFreq; prevP = perFreq;
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int pllLat;
    repeat (3) @(negedge clk);
    // R7: reset values
    check("R7", "coreFreq reset", coreFreq, 32'd0);
    check("R7", "perFreq reset", perFreq, 32'd0);
    check("R7", "done reset", {31'b0, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R3 R5: PLL off, fast reference, both dividers active
    setIn(2'b00, 1'b0, 1'b0, 4'd1, 10'd0, 4'd6, 10'd0, 3'd3, 2'd1);
    pulseStart("R4"); drain();
    // R3: scaled slow reference, bypass
    setIn(2'b10, 1'b0, 1'b0, 4'd0, 10'd0, 4'd6, 10'd0, 3'd7, 2'd3);
    pulseStart("R3"); drain();
    // R3: refSel 2'b11 stays on the fast reference
    setIn(2'b11, 1'b0, 1'b0, 4'd0, 10'd0, 4'd6, 10'd0, 3'd0, 2'd0);
    pulseStart("R3"); drain();
    // R1: PLL path, integer 6, pre-divider field 1; latency measured here
    setIn(2'b00, 1'b1, 1'b0, 4'd1, 10'd0, 4'd6, 10'd0, 3'd1, 2'd1);
    pulseStart("R1"); drain();
    pllLat = lastDoneCyc - startCyc;
    // R1: integer field below the floor is clamped to 5
    setIn(2'b00, 1'b1, 1'b0, 4'd0, 10'd4, 4'd2, 10'd3, 3'd0, 2'd2);
    pulseStart("R1"); drain();
    // R2: negative numerator, slow reference
    setIn(2'b10, 1'b1, 1'b0, 4'd2, 10'd99, 4'd10, 10'h3F0, 3'd2, 2'd0);
    pulseStart("R2"); drain();
    // R2: most negative numerator with integer 5, sum wraps negative
    setIn(2'b00, 1'b1, 1'b0, 4'd15, 10'd0, 4'd0, 10'h200, 3'd0, 2'd0);
    pulseStart("R2"); drain();
    // R4: forceRef overrides an enabled PLL
    setIn(2'b00, 1'b1, 1'b1, 4'd1, 10'd4, 4'd12, 10'd1, 3'd4, 2'd3);
    pulseStart("R4"); drain();

    // R8: inputs changed right after launch do not alter the result
    setIn(2'b00, 1'b1, 1'b0, 4'd3, 10'd7, 4'd9, 10'd100, 3'd1, 2'd1);
    pulseStart("R8");
    setIn(2'b10, 1'b0, 1'b1, 4'd0, 10'd0, 4'd0, 10'd0, 3'd7, 2'd3);
    drain();

    // R9: two strobes during a run give exactly one extra run with new inputs
    setIn(2'b00, 1'b1, 1'b0, 4'd1, 10'd0, 4'd6, 10'd0, 3'd2, 2'd1);
    pulseStart("R9");
    repeat (10) @(negedge clk);
    setIn(2'b10, 1'b1, 1'b0, 4'd0, 10'd3, 4'd8, 10'd5, 3'd1, 2'd2);
    pulseStart("R9");
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    drain();
    repeat (300) @(negedge clk);
    check("R9", "pending results left", expCore.size(), 32'd0);

    // R10: start lands on the exact edge that publishes a result
    setIn(2'b00, 1'b1, 1'b0, 4'd1, 10'd0, 4'd6, 10'd0, 3'd0, 2'd0);
    pulseStart("R10");
    while (cyc < startCyc + pllLat - 1) @(negedge clk);
    setIn(2'b00, 1'b0, 1'b0, 4'd0, 10'd0, 4'd5, 10'd0, 3'd5, 2'd2);
    pushExp("R10");
    start = 1'b1;
    @(negedge clk);
    check("R10", "done on strobe edge", {31'b0, done}, 32'd1);
    start = 1'b0;
    drain();
    repeat (300) @(negedge clk);
    check("R10", "pending results left", expCore.size(), 32'd0);

    finishRun();
  end
endmodule